// File: doc/BRIEF.md
# NAND Flash Page Program Sequencer

This block writes one page at a time into an 8-bit asynchronous NAND flash device whose commands, addresses and data all travel over one shared byte bus. A client hands it a page address through a valid/ready request port and then streams the page contents one byte at a time through a second valid/ready port. The controller drives chip enable, the two latch-enable strobes and write enable, and puts each byte on the bus. The device tells command, address and data bytes apart only by the latch-enable levels it sees on the rising edge of write enable.

One page program is a fixed sequence: a setup command, the address bytes with the least significant byte first, the page data, and a confirm command. The controller then ignores the ready/busy line for a blind window, because the device needs time to pull the line low. After that it waits for the line to go high again and pulses done for one cycle. The ready/busy input is asynchronous and passes through a synchronizer. Every bus cycle uses the same write-enable waveform: a setup phase, a low phase and a high phase, each a parameter in clock cycles. The read strobe is held inactive, because this block only writes.

Top module: `nand_prog_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, chip enable, write enable and read enable are high (inactive), both latch enables are low, the bus enable is low, req_ready is high, and data_ready and done are low.
- R2: The first byte strobed after a request is accepted is the setup command CMD_SETUP (default 0x80), with CLE high and ALE low.
- R3: The next ADDR_BYTES strobes have ALE high and CLE low. They carry req_page captured at acceptance, least significant byte first (bits [7:0], then [15:8], and so on).
- R4: The next PAGE_BYTES strobes have CLE and ALE both low. They carry the bytes accepted on the data port, in the order they were accepted.
- R5: The last strobe of the operation is the confirm command CMD_CONFIRM (default 0x10), with CLE high and ALE low.
- R6: Write enable stays low for exactly WE_LOW_CYC cycles in each bus cycle. CLE, ALE, the bus value and the bus enable are held unchanged for at least SETUP_CYC cycles before write enable falls and throughout the low phase, and the bus enable is high while write enable is low.
- R7: CLE and ALE are never high in the same cycle.
- R8: Read enable is never driven low, and chip enable is low in every cycle in which write enable is low.
- R9: For BUSY_DLY cycles after the confirm bus cycle ends, ready/busy is not looked at, so a busy indication that arrives late is not missed. Once that window has passed, done goes high exactly SYNC_STAGES+1 cycles after ready/busy returns high.
- R10: done is high for exactly one cycle. req_ready is low from the cycle after acceptance through the done cycle, and changes on req_valid or req_page during that time have no effect. A request that is still held is accepted at the earliest in the cycle after done.
- R11: data_ready is high only in the data phase when no byte is in flight. While data_valid is low no data strobe occurs and write enable stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Program request valid |
| req_ready | output | 1 | Controller idle, can accept a request |
| req_page | input | ADDR_BYTES*8 | Page address sent as column and row bytes, LSB first |
| data_valid | input | 1 | Page data byte valid |
| data_ready | output | 1 | Controller takes a data byte this cycle |
| data_byte | input | 8 | Page data byte |
| done | output | 1 | One-cycle pulse when the device has finished programming |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low; bytes are latched on its rising edge |
| nand_re_n | output | 1 | Read enable, active low; held high |
| nand_io_out | output | 8 | Byte driven onto the shared bus |
| nand_io_oe | output | 1 | Bus drive enable |
| nand_rb | input | 1 | Ready/busy from the device, low while busy |

## Verification
Two of the block's functions can fall in the same cycle: the done pulse that ends one operation, and the acceptance of a request the client has held valid for the whole of that operation. The bench provokes this by keeping req_valid high from the first request onward and changing req_page partway through. It then checks three things: req_ready is still low in the done cycle and high in the cycle after it, the first operation's address bytes carry the page captured at first acceptance, and the second operation carries the changed page. A second overlap is a device that asserts busy late, inside the blind window that follows the confirm byte. That case is judged by requiring that done comes only after ready/busy has gone low and then returned high.

// File: rtl/nand_prog_pkg.sv
package nand_prog_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LOW,
    PH_HOLD
  } we_phase_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD_SETUP,
    ST_ADDR,
    ST_DATA,
    ST_CMD_CONF,
    ST_BLIND,
    ST_WAIT_RB,
    ST_DONE
  } prog_state_t;

endpackage

// File: rtl/nand_sync_bit.sv
module nand_sync_bit #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/nand_we_seq.sv
module nand_we_seq
  import nand_prog_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int WE_LOW_CYC  = 2,
  parameter int WE_HIGH_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] byte_in,
  input  logic       cle_in,
  input  logic       ale_in,
  output logic       busy,
  output logic       fin,
  output logic       we_n,
  output logic       cle,
  output logic       ale,
  output logic [7:0] io,
  output logic       oe
);

  localparam int MAXC = (SETUP_CYC > WE_LOW_CYC) ?
                        ((SETUP_CYC > WE_HIGH_CYC) ? SETUP_CYC : WE_HIGH_CYC) :
                        ((WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LD_SETUP = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LD_LOW   = CW'(WE_LOW_CYC - 1);
  localparam logic [CW-1:0] LD_HOLD  = CW'(WE_HIGH_CYC - 1);

  we_phase_t     ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          load;
  logic [7:0]    io_q, io_d;
  logic          cle_q, cle_d, ale_q, ale_d, oe_q, oe_d, we_n_q, we_n_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    load  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (go) begin
          ph_d  = PH_SETUP;
          cnt_d = LD_SETUP;
          load  = 1'b1;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          ph_d  = PH_LOW;
          cnt_d = LD_LOW;
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_LOW: begin
        if (cnt_q == '0) begin
          ph_d  = PH_HOLD;
          cnt_d = LD_HOLD;
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_HOLD: begin
        if (cnt_q == '0) ph_d = PH_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_comb begin
    io_d  = io_q;
    cle_d = cle_q;
    ale_d = ale_q;
    oe_d  = oe_q;
    if (load) begin
      io_d  = byte_in;
      cle_d = cle_in;
      ale_d = ale_in;
      oe_d  = 1'b1;
    end else if (ph_d == PH_IDLE) begin
      io_d  = 8'h00;
      cle_d = 1'b0;
      ale_d = 1'b0;
      oe_d  = 1'b0;
    end
    we_n_d = (ph_d != PH_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      io_q   <= 8'h00;
      cle_q  <= 1'b0;
      ale_q  <= 1'b0;
      oe_q   <= 1'b0;
      we_n_q <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      io_q   <= io_d;
      cle_q  <= cle_d;
      ale_q  <= ale_d;
      oe_q   <= oe_d;
      we_n_q <= we_n_d;
    end
  end

  assign busy = (ph_q != PH_IDLE);
  assign fin  = (ph_q == PH_HOLD) && (cnt_q == '0);
  assign we_n = we_n_q;
  assign cle  = cle_q;
  assign ale  = ale_q;
  assign io   = io_q;
  assign oe   = oe_q;

  // R6: latched values do not move while write enable is low
  a_r6_low_phase_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_q && $past(!we_n_q)) |-> ($stable(io_q) && $stable(cle_q) && $stable(ale_q)));

  // R6: bus is driven whenever write enable is low
  a_r6_bus_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> oe_q);

  // R7: command and address latches never overlap
  a_r7_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle_q && ale_q));

endmodule

// File: rtl/nand_prog_ctrl.sv
module nand_prog_ctrl
  import nand_prog_pkg::*;
#(
  parameter int         ADDR_BYTES  = 4,
  parameter int         PAGE_BYTES  = 16,
  parameter int         SETUP_CYC   = 2,
  parameter int         WE_LOW_CYC  = 2,
  parameter int         WE_HIGH_CYC = 2,
  parameter int         BUSY_DLY    = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CMD_SETUP   = 8'h80,
  parameter logic [7:0] CMD_CONFIRM = 8'h10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_BYTES*8-1:0] req_page,
  input  logic                    data_valid,
  output logic                    data_ready,
  input  logic [7:0]              data_byte,
  output logic                    done,
  output logic                    nand_ce_n,
  output logic                    nand_cle,
  output logic                    nand_ale,
  output logic                    nand_we_n,
  output logic                    nand_re_n,
  output logic [7:0]              nand_io_out,
  output logic                    nand_io_oe,
  input  logic                    nand_rb
);

  localparam int ADDR_W  = ADDR_BYTES * 8;
  localparam int CNT_MAX = (ADDR_BYTES > PAGE_BYTES) ? ADDR_BYTES : PAGE_BYTES;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int DW      = $clog2(BUSY_DLY + 1);
  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_BYTES - 1);
  localparam logic [CW-1:0] PAGE_LAST = CW'(PAGE_BYTES - 1);
  localparam logic [DW-1:0] BLIND_LD  = DW'(BUSY_DLY - 1);

  logic rst_n_s;
  logic rb_s;

  nand_sync_bit #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  nand_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rb_sync (
    .clk(clk), .arst_n(rst_n_s), .d(nand_rb), .q(rb_s)
  );

  prog_state_t       st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DW-1:0]     dly_q, dly_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic              launched_q, launched_d;
  logic              go, sfin, sbusy, s_cle, s_ale;
  logic [7:0]        s_byte;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    dly_d   = dly_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    go      = 1'b0;
    s_byte  = 8'h00;
    s_cle   = 1'b0;
    s_ale   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d    = ST_CMD_SETUP;
          addr_d  = req_page;
          addr_en = 1'b1;
        end
      end
      ST_CMD_SETUP: begin
        s_cle  = 1'b1;
        s_byte = CMD_SETUP;
        go     = !launched_q;
        if (sfin) begin
          st_d  = ST_ADDR;
          cnt_d = '0;
        end
      end
      ST_ADDR: begin
        s_ale  = 1'b1;
        s_byte = addr_q[7:0];
        go     = !launched_q;
        if (sfin) begin
          addr_d  = addr_q >> 8;
          addr_en = 1'b1;
          if (cnt_q == ADDR_LAST) begin
            st_d  = ST_DATA;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DATA: begin
        s_byte = data_byte;
        go     = data_valid && !launched_q;
        if (sfin) begin
          if (cnt_q == PAGE_LAST) st_d = ST_CMD_CONF;
          else                    cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CMD_CONF: begin
        s_cle  = 1'b1;
        s_byte = CMD_CONFIRM;
        go     = !launched_q;
        if (sfin) begin
          st_d  = ST_BLIND;
          dly_d = BLIND_LD;
        end
      end
      ST_BLIND: begin
        if (dly_q == '0) st_d = ST_WAIT_RB;
        else             dly_d = dly_q - 1'b1;
      end
      ST_WAIT_RB: begin
        if (rb_s) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    launched_d = launched_q;
    if (go)        launched_d = 1'b1;
    else if (sfin) launched_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      dly_q      <= '0;
      launched_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      dly_q      <= dly_d;
      launched_q <= launched_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  nand_we_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .WE_LOW_CYC (WE_LOW_CYC),
    .WE_HIGH_CYC(WE_HIGH_CYC)
  ) u_we_seq (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .go     (go),
    .byte_in(s_byte),
    .cle_in (s_cle),
    .ale_in (s_ale),
    .busy   (sbusy),
    .fin    (sfin),
    .we_n   (nand_we_n),
    .cle    (nand_cle),
    .ale    (nand_ale),
    .io     (nand_io_out),
    .oe     (nand_io_oe)
  );

  assign req_ready  = (st_q == ST_IDLE);
  assign data_ready = (st_q == ST_DATA) && !launched_q;
  assign done       = (st_q == ST_DONE);
  assign nand_ce_n  = (st_q == ST_IDLE);
  assign nand_re_n  = 1'b1;

  // R4: the controller only launches a byte into an idle strobe engine
  a_r4_launch_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    !launched_q |-> !sbusy);

  // R8: the device is selected whenever a byte is being strobed
  a_r8_ce_during_we: assert property (@(posedge clk) disable iff (!rst_n_s)
    !nand_we_n |-> !nand_ce_n);

  // R9: completion is reported only with the device ready
  a_r9_rb_high_at_done: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(done) |-> nand_rb);

  // R10: done is a single-cycle pulse
  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);

  // R10: no request is taken while completion is being reported
  a_r10_no_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !req_ready);

  // R11: a data byte is only taken with write enable idle
  a_r11_data_ready_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    data_ready |-> nand_we_n);

endmodule

// File: tb/nand_prog_ctrl_test.sv
module nand_prog_ctrl_test;

  localparam int AB   = 4;
  localparam int PB   = 16;
  localparam int SUC  = 2;
  localparam int WLC  = 2;
  localparam int WHC  = 2;
  localparam int BDLY = 4;
  localparam int SYNC = 2;

  logic          clk, rst_n;
  logic          req_valid, req_ready;
  logic [AB*8-1:0] req_page;
  logic          data_valid, data_ready;
  logic [7:0]    data_byte;
  logic          done;
  logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]    nand_io_out;
  logic          nand_rb;

  nand_prog_ctrl #(
    .ADDR_BYTES(AB), .PAGE_BYTES(PB), .SETUP_CYC(SUC), .WE_LOW_CYC(WLC),
    .WE_HIGH_CYC(WHC), .BUSY_DLY(BDLY), .SYNC_STAGES(SYNC),
    .CMD_SETUP(8'h80), .CMD_CONFIRM(8'h10)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .data_valid(data_valid), .data_ready(data_ready),
    .data_byte(data_byte), .done(done), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_rb(nand_rb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash model log: kind 2=command, 1=address, 0=data, 3=both latches
  int         log_n = 0;
  logic [1:0] log_kind [0:63];
  logic [7:0] log_val  [0:63];
  int         conf_cnt = 0;

  always @(posedge nand_we_n) begin
    if (rst_n === 1'b1) begin
      if (log_n < 64) begin
        log_kind[log_n] = {nand_cle, nand_ale};
        log_val[log_n]  = nand_io_out;
      end
      log_n++;
      if (nand_cle && !nand_ale && nand_io_out == 8'h10) conf_cnt++;
    end
  end

  // monitor and busy model, sampled away from the active edge
  bit   mon_on = 0;
  int   cyc = 0;
  int   viol_r6 = 0, viol_r7 = 0, viol_r8 = 0, viol_r9 = 0, viol_r10 = 0, viol_r11 = 0;
  logic [10:0] prev_sig = '0;
  logic prev_we = 1'b1, prev_done = 1'b0;
  int   stable = 0, low_cnt = 0;
  int   bz_delay = 1, bz_len = 12;
  int   conf_seen = 0, bz_ph = 0, bz_wait = 0;
  bit   busy_seen = 0;
  int   rb_rise_cyc = -100;
  int   done_cnt = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      logic [10:0] sig;
      cyc++;
      sig = {nand_cle, nand_ale, nand_io_oe, nand_io_out};
      if (sig == prev_sig) stable++; else stable = 0;
      if (nand_cle && nand_ale) viol_r7++;
      if (!nand_we_n && prev_we && stable < SUC) viol_r6++;
      if (!nand_we_n && !prev_we && sig != prev_sig) viol_r6++;
      if (!nand_we_n && !nand_io_oe) viol_r6++;
      if (!nand_we_n) low_cnt++;
      if (nand_we_n && !prev_we) begin
        if (low_cnt != WLC) viol_r6++;
        low_cnt = 0;
      end
      if (!nand_re_n) viol_r8++;
      if (!nand_we_n && nand_ce_n) viol_r8++;
      if (req_ready && !nand_ce_n) viol_r10++;
      if (done && prev_done) viol_r10++;
      if (data_ready && !nand_we_n) viol_r11++;
      if (done) begin
        done_cnt++;
        if (!busy_seen || (cyc - rb_rise_cyc) != SYNC + 1) viol_r9++;
        busy_seen = 0;
      end
      prev_sig  = sig;
      prev_we   = nand_we_n;
      prev_done = done;
      // busy model
      if (conf_cnt != conf_seen) begin
        conf_seen = conf_cnt;
        bz_ph     = 1;
        bz_wait   = bz_delay;
      end else if (bz_ph == 1) begin
        bz_wait--;
        if (bz_wait == 0) begin
          nand_rb   = 1'b0;
          busy_seen = 1;
          bz_ph     = 2;
          bz_wait   = bz_len;
        end
      end else if (bz_ph == 2) begin
        bz_wait--;
        if (bz_wait == 0) begin
          nand_rb     = 1'b1;
          rb_rise_cyc = cyc;
          bz_ph       = 0;
        end
      end
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed + i * 29) & 8'hff);
  endfunction

  task automatic feed_data(input int seed, input int gap);
    for (int i = 0; i < PB; i++) begin
      if (gap > 0) begin
        int n0;
        data_valid = 1'b0;
        while (!data_ready) @(negedge clk);
        n0 = log_n;
        repeat (gap) @(negedge clk);
        // R11: no strobe while the source stalls
        check(log_n == n0 && nand_we_n, "R11 stall", log_n, n0);
      end
      data_valid = 1'b1;
      data_byte  = pat(seed, i);
      while (!data_ready) @(negedge clk);
      @(negedge clk);
    end
    data_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic check_log(input logic [AB*8-1:0] page, input int seed, input string tag);
    int errs;
    check(log_n == AB + PB + 2, {tag, " strobe count R2"}, log_n, AB + PB + 2);
    if (log_n == AB + PB + 2) begin
      check(log_kind[0] == 2'b10 && log_val[0] == 8'h80, {tag, " R2 setup cmd"},
            {log_kind[0], log_val[0]}, 10'h280);
      for (int i = 0; i < AB; i++)
        check(log_kind[1+i] == 2'b01 && log_val[1+i] == page[i*8 +: 8], {tag, " R3 addr byte"},
              {log_kind[1+i], log_val[1+i]}, {2'b01, page[i*8 +: 8]});
      errs = 0;
      for (int i = 0; i < PB; i++)
        if (log_kind[1+AB+i] != 2'b00 || log_val[1+AB+i] != pat(seed, i)) errs++;
      check(errs == 0, {tag, " R4 data bytes"}, errs, 0);
      check(log_kind[AB+PB+1] == 2'b10 && log_val[AB+PB+1] == 8'h10, {tag, " R5 confirm"},
            {log_kind[AB+PB+1], log_val[AB+PB+1]}, 10'h210);
    end
  endtask

  task automatic run_program(input logic [AB*8-1:0] page, input int seed, input int gap,
                             input int bd, input int bl, input string tag);
    int d0;
    @(negedge clk);
    bz_delay  = bd;
    bz_len    = bl;
    log_n     = 0;
    d0        = done_cnt;
    req_valid = 1'b1;
    req_page  = page;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    feed_data(seed, gap);
    wait_done();
    @(negedge clk);
    check(done == 1'b0 && done_cnt == d0 + 1, {tag, " R10 single done"}, done_cnt - d0, 1);
    check_log(page, seed, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_page = '0; data_valid = 1'b0;
    data_byte = 8'h00; nand_rb = 1'b1;
    repeat (3) @(negedge clk);
    check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe,
          "R1 pins in reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe}, 6'b111000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1;
    check(req_ready && !data_ready && !done, "R1 handshake idle",
          {req_ready, data_ready, done}, 3'b100);
    check(nand_ce_n && nand_we_n && !nand_io_oe && log_n == 0, "R1 pins idle",
          {nand_ce_n, nand_we_n, nand_io_oe}, 3'b110);
  endtask

  task automatic t_basic();
    run_program(32'h1234_5678, 3, 0, 1, 12, "basic");
  endtask

  task automatic t_gaps();
    run_program(32'hA5C3_0F01, 100, 3, 2, 15, "gaps R11");
  endtask

  task automatic t_late_busy();
    // R9: busy appears late, inside the blind window
    run_program(32'h0000_00FF, 7, 0, BDLY - 1, 30, "late busy R9");
  endtask

  task automatic t_overlap();
    logic [AB*8-1:0] pa, pb;
    pa = 32'hDEAD_BEEF;
    pb = 32'h0102_0304;
    @(negedge clk);
    bz_delay = 1; bz_len = 10; log_n = 0;
    req_valid = 1'b1;
    req_page  = pa;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_page = pb;            // R10: changed while busy, held valid
    check(!req_ready, "R10 ready drops", req_ready, 0);
    feed_data(50, 0);
    wait_done();
    check(!req_ready, "R10 not ready at done", req_ready, 0);
    check_log(pa, 50, "overlap first");
    @(negedge clk);
    check(req_ready && !done, "R10 ready after done", {req_ready, done}, 2'b10);
    log_n = 0;
    @(negedge clk);
    req_valid = 1'b0;
    feed_data(77, 0);
    wait_done();
    @(negedge clk);
    check_log(pb, 77, "overlap second");
  endtask

  task automatic t_monitors();
    check(viol_r6 == 0, "R6 strobe timing", viol_r6, 0);
    check(viol_r7 == 0, "R7 latch exclusive", viol_r7, 0);
    check(viol_r8 == 0, "R8 select and read enable", viol_r8, 0);
    check(viol_r9 == 0, "R9 ready/busy tracking", viol_r9, 0);
    check(viol_r10 == 0, "R10 ready and done pulse", viol_r10, 0);
    check(viol_r11 == 0, "R11 data ready", viol_r11, 0);
    check(done_cnt == 5, "R10 done count", done_cnt, 5);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_gaps();
    t_late_busy();
    t_overlap();
    repeat (5) @(negedge clk);
    t_monitors();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule